// File: doc/BRIEF.md
# Tagged-Byte Message Deframer

This block sits behind the receive buffer of a ring network node. Each buffer entry is a 10-bit element: a 2-bit tag in bits 9:8 and a byte in bits 7:0. The block waits until the buffer reports that it holds data. It then consumes one element per clock. For each element it takes, it raises a read-advance strobe so that the buffer moves on to its next entry.

A message begins with a header element. The source node number sits in the header's upper nibble. The next element carries a type byte. After that, payload bytes with tag 00 are gathered four at a time into 32-bit words. The first byte of each group lands in the least significant position. Each completed word is presented for one cycle on a valid output. The first element with a nonzero tag closes the message. The block then pulses a done output together with the source, the type and the number of complete words, and goes back to looking for a header.

Top module: `msg_deframer`

## Requirements
- R1: While rst_n is low, rx_adv, word_valid and msg_done are all 0.
- R2: The block never pulses rx_adv while rx_empty is 1, so it does not read the header or any later element from an empty buffer.
- R3: Every cycle outside reset in which rx_empty is 0, the block consumes the presented element and raises rx_adv for exactly that cycle, including while idle and waiting for a header.
- R4: The source node reported with msg_done equals bits 7:4 of the header element, the first element consumed after the previous message ended.
- R5: The element right after the header is reported as the type byte (its bits 7:0) and never enters a payload word.
- R6: Payload bytes (tag bits 9:8 equal to 00) are packed little-endian: the 1st, 2nd, 3rd and 4th bytes of a group go to word_data bits 7:0, 15:8, 23:16 and 31:24. word_valid is high for one cycle, starting the cycle after the fourth byte is consumed.
- R7: Any payload-position element whose tag is 01, 10 or 11 ends the message. That element is consumed and contributes no data.
- R8: word_count reported with msg_done equals the number of complete four-byte groups. A leftover group of one to three bytes is dropped and not counted.
- R9: msg_done is high for exactly one cycle, starting the cycle after the ending element is consumed, and never in the same cycle as word_valid. src_node, msg_type and word_count keep the finished message's values during that cycle, even while the next header is being consumed.
- R10: A message with no payload bytes completes with word_count 0 and no word_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_empty | input | 1 | Receive buffer holds no element |
| rx_elem | input | 10 | Element at the buffer's read position: tag in 9:8, byte in 7:0 |
| rx_adv | output | 1 | Read-advance strobe, one per consumed element |
| word_valid | output | 1 | word_data holds a newly completed word |
| word_data | output | 32 | Reassembled little-endian word |
| msg_done | output | 1 | One-cycle end-of-message pulse |
| src_node | output | 4 | Source node of the message |
| msg_type | output | 8 | Type byte of the message |
| word_count | output | CNT_W | Complete words in the message |

## Verification
The done pulse of one message falls in the same cycle as the header read of the next message whenever the two messages sit back to back in the buffer. The bench provokes this by queueing messages with no gap between them. It then requires that src_node, msg_type and word_count seen with msg_done still belong to the message just closed, while rx_adv is already taking the next header. A second coincidence comes from a fourth byte directly followed by a trailer: the word_valid pulse overlaps the trailer read. The bench judges that word_valid and msg_done then appear in consecutive cycles and never together.

// File: rtl/msg_deframer.sv
module msg_deframer #(
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_empty,
  input  logic [9:0]              rx_elem,
  output logic                    rx_adv,
  output logic                    word_valid,
  output logic [8*WORD_BYTES-1:0] word_data,
  output logic                    msg_done,
  output logic [3:0]              src_node,
  output logic [7:0]              msg_type,
  output logic [CNT_W-1:0]        word_count
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

  typedef enum logic [1:0] {ST_HDR, ST_TYPE, ST_DATA} state_t;
  state_t state;

  logic [IDX_W-1:0]  byte_idx;
  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] shifted;
  logic              is_data;

  assign rx_adv  = rst_n & ~rx_empty;
  assign is_data = (rx_elem[9:8] == 2'b00);
  assign shifted = {rx_elem[7:0], asm_q[WORD_W-1:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_HDR;
      byte_idx   <= '0;
      asm_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      msg_done   <= 1'b0;
      src_node   <= '0;
      msg_type   <= '0;
      word_count <= '0;
    end else begin
      word_valid <= 1'b0;
      msg_done   <= 1'b0;
      if (rx_adv) begin
        unique case (state)
          ST_HDR: begin
            src_node <= rx_elem[7:4];
            state    <= ST_TYPE;
          end
          ST_TYPE: begin
            msg_type   <= rx_elem[7:0];
            word_count <= '0;
            byte_idx   <= '0;
            state      <= ST_DATA;
          end
          ST_DATA: begin
            if (is_data) begin
              asm_q <= shifted;
              if (byte_idx == LAST_IDX) begin
                word_data  <= shifted;
                word_valid <= 1'b1;
                word_count <= word_count + 1'b1;
                byte_idx   <= '0;
              end else begin
                byte_idx <= byte_idx + 1'b1;
              end
            end else begin
              msg_done <= 1'b1;
              state    <= ST_HDR;
            end
          end
          default: state <= ST_HDR;
        endcase
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);

  // R9
  done_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_done && word_valid));

  // R7
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> $past(rx_adv));

  // R6
  word_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_count == $past(word_count) + 1'b1);

  // R2
  no_read_empty_chk: assert property (@(posedge clk)
    rx_empty |-> !rx_adv);
endmodule

// File: tb/msg_deframer_tb.sv
module msg_deframer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_empty = 1'b1;
  logic [9:0]       rx_elem = '0;
  logic             rx_adv;
  logic             word_valid;
  logic [31:0]      word_data;
  logic             msg_done;
  logic [3:0]       src_node;
  logic [7:0]       msg_type;
  logic [CNT_W-1:0] word_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_deframer #(.WORD_BYTES(4), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_empty(rx_empty), .rx_elem(rx_elem),
    .rx_adv(rx_adv), .word_valid(word_valid), .word_data(word_data),
    .msg_done(msg_done), .src_node(src_node), .msg_type(msg_type),
    .word_count(word_count));

  int checks = 0;
  int errors = 0;
  logic [9:0] q[$];
  bit took = 0;
  int mst = 0, mnb = 0, mcnt = 0;
  logic [31:0] masm = '0;
  logic [3:0] msrc = '0;
  logic [7:0] mtype = '0;
  bit exp_wv, exp_done;
  logic [31:0] exp_wd;
  logic [9:0] e;
  int cyc = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      exp_wv = 0; exp_done = 0;
      if (took) begin
        e = q.pop_front();
        case (mst)
          0: begin msrc = e[7:4]; mst = 1; end
          1: begin mtype = e[7:0]; mcnt = 0; mnb = 0; masm = 0; mst = 2; end
          default: begin
            if (e[9:8] == 2'b00) begin
              masm = masm | (32'(e[7:0]) << (8*mnb));
              mnb++;
              if (mnb == 4) begin
                exp_wv = 1; exp_wd = masm; mcnt++; masm = 0; mnb = 0;
              end
            end else begin
              exp_done = 1; mst = 0;
            end
          end
        endcase
      end
      chk(word_valid == exp_wv, "R6 word_valid", word_valid, exp_wv);
      if (exp_wv) chk(word_data == exp_wd, "R6 word_data", word_data, exp_wd);
      chk(msg_done == exp_done, "R9 msg_done", msg_done, exp_done);
      if (exp_done) begin
        chk(src_node == msrc, "R4 src_node", src_node, msrc);
        chk(msg_type == mtype, "R5 msg_type", msg_type, mtype);
        chk(word_count == CNT_W'(mcnt), "R8 R10 word_count", word_count, mcnt);
      end
    end
    rx_empty = (q.size() == 0);
    rx_elem  = rx_empty ? 10'h000 : q[0];
    #1;
    if (rst_n) begin
      chk(rx_adv == !rx_empty, "R3 R2 rx_adv", rx_adv, !rx_empty);
      took = rx_adv;
    end else took = 0;
  end

  task automatic push(logic [9:0] v, int gap);
    @(posedge clk);
    q.push_back(v);
    repeat (gap) @(posedge clk);
  endtask

  task automatic send_msg(int src, int dst, int typ, int nbytes, int base,
                          logic [1:0] trl, int gap);
    push({2'b10, 4'(src), 4'(dst)}, gap);
    push({2'b00, 8'(typ)}, gap);
    for (int i = 0; i < nbytes; i++) push({2'b00, 8'(base + i*17)}, gap);
    push({trl, 8'h00}, gap);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(rx_adv == 0, "R1 rx_adv", rx_adv, 0);
    chk(word_valid == 0, "R1 word_valid", word_valid, 0);
    chk(msg_done == 0, "R1 msg_done", msg_done, 0);
    @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    send_msg(5, 3, 8'h7A, 8, 8'h10, 2'b01, 0);
    send_msg(9, 1, 8'h33, 0, 0, 2'b10, 0);
    send_msg(2, 7, 8'hC4, 6, 8'hA0, 2'b11, 0);
    repeat (6) @(posedge clk);
    send_msg(15, 4, 8'h01, 3, 8'h55, 2'b01, 0);
    send_msg(11, 0, 8'hE9, 12, 8'h02, 2'b01, 3);
    send_msg(0, 15, 8'h44, 5, 8'hF0, 2'b10, 1);
    while (q.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    chk(mst == 0, "R7 message closed", mst, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule